// File: doc/BRIEF.md
# Integer Result Flag Generator

This block derives the fixed-point status flags that follow an integer operation: carry, 32-bit carry, overflow, 32-bit overflow and the sticky summary overflow. It also derives a 4-bit condition field that classifies the signed result. The ALU hands over its register operands, an optional immediate, the 64-bit result and a set of control strobes. The flags are then inferred from those values rather than from an adder's carry-out. Carry is inferred by unsigned comparison of operands against the result. Overflow is inferred from operand and result signs. A divide unit can supply its own overflow verdict instead.

The flags and the condition field live in registers inside the block. They are updated on the clock edge that closes a cycle with `opValid` high. Each flag group is written only when its enable is set and the instruction has not already produced that flag itself. The sticky summary-overflow bit is cleared only by reset.

Top module: `intFlagUnit`

## Requirements
- R1: After reset, `flagCa`, `flagCa32`, `flagOv`, `flagOv32`, `flagSo` and `condField` are all 0.
- R2: The operand list is built as follows. First come the first `opCount` register operands, in the order `opA`, `opB`, `opC`. When `immValid` is 1, `immData` is appended directly after them. When `invertA` is 1 and `opCount` is at least 1, `opA` enters the list bit-inverted.
- R3: On an update with `carryEn` = 1, CA becomes 1 exactly when some listed operand, read as unsigned, is greater than `result`.
- R4: With `isAdd` = 1, CA32 becomes `result[32]` XOR bit 32 of the first listed operand XOR bit 32 of the second listed operand. A missing operand counts as 0.
- R5: With `isAdd` = 0, CA32 becomes 1 exactly when the low 32 bits of some listed operand, read as unsigned, exceed `result[31:0]`.
- R6: `doneMask[0]` = 1 leaves CA unchanged and `doneMask[1]` = 1 leaves CA32 unchanged. Each mask bit affects only its own flag.
- R7: On an overflow update without the divide override, the rule uses the first two listed operands. OV = 1 when those two operands agree in bit 63 and `result[63]` differs from them. OV32 applies the same rule to bit 31.
- R8: When `divOvValid` = 1 on an overflow update, both OV and OV32 take `divOvValue`.
- R9: An overflow update ORs the new OV into SO. Once SO is 1, it stays 1 until reset.
- R10: An overflow update needs `ovEn` = 1 and also either at least two listed operands or `divOvValid` = 1. Without this, OV, OV32 and SO keep their values.
- R11: When `recEn` = 1, `condField` becomes {negative, positive, zero, SO} in bits 3..0. The first three bits come from `result` read as signed. SO is the value after this update's overflow step.
- R12: Nothing changes when `opValid` = 0. When `opValid` = 1, the following also leave their fields unchanged: `carryEn` = 0 (CA, CA32), `ovEn` = 0 (OV, OV32, SO) and `recEn` = 0 (`condField`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation completes this cycle; registers update at the edge |
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand |
| opC | input | 64 | Third register operand |
| opCount | input | 2 | Number of register operands in use (0..3) |
| invertA | input | 1 | Invert the first operand before evaluation |
| immValid | input | 1 | Immediate operand present |
| immData | input | 64 | Immediate operand value |
| isAdd | input | 1 | Select the add rule for CA32 |
| carryEn | input | 1 | Update CA and CA32 |
| ovEn | input | 1 | Update OV, OV32 and SO |
| recEn | input | 1 | Update the condition field |
| divOvValid | input | 1 | Divide overflow override present |
| divOvValue | input | 1 | Divide overflow override value |
| doneMask | input | 2 | Flags already written by the instruction: bit 0 CA, bit 1 CA32 |
| result | input | 64 | Operation result |
| flagCa | output | 1 | Carry |
| flagCa32 | output | 1 | 32-bit carry |
| flagOv | output | 1 | Overflow |
| flagOv32 | output | 1 | 32-bit overflow |
| flagSo | output | 1 | Sticky summary overflow |
| condField | output | 4 | {negative, positive, zero, SO} |

## Verification
The bench builds the block with its default 64-bit data width and three register operand slots. This makes the 32-bit and 64-bit boundaries different bit positions, so that cases such as a 32-bit-only signed overflow, or a carry out of bit 31 that does not reach bit 63, can be told apart. With three register slots, the immediate can be placed directly after one register operand, which shows how the immediate moves into the second-operand position.

// File: rtl/intFlagPkg.sv
package intFlagPkg;
  typedef struct packed {
    logic wrCarry;
    logic wrCarry32;
    logic wrOver;
    logic wrCond;
  } flagStrobes_t;
endpackage

// File: rtl/flagControl.sv
module flagControl
  import intFlagPkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             opValid,
  input  logic [CNT_W-1:0] opCount,
  input  logic             immValid,
  input  logic             carryEn,
  input  logic             ovEn,
  input  logic             recEn,
  input  logic             divOvValid,
  input  logic [1:0]       doneMask,
  output flagStrobes_t     strobes
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] listLen;
  logic             ovAllowed;

  assign listLen   = SUM_W'(opCount) + SUM_W'(immValid);
  assign ovAllowed = (listLen >= SUM_W'(2)) || divOvValid;

  always_comb begin
    strobes.wrCarry   = opValid && carryEn && !doneMask[0];
    strobes.wrCarry32 = opValid && carryEn && !doneMask[1];
    strobes.wrOver    = opValid && ovEn && ovAllowed;
    strobes.wrCond    = opValid && recEn;
  end
endmodule

// File: rtl/flagDatapath.sv
module flagDatapath #(
  parameter int DATA_W      = 64,
  parameter int NUM_REG_OPS = 3,
  parameter int CNT_W       = 2
) (
  input  logic [DATA_W-1:0] regOps [NUM_REG_OPS],
  input  logic [CNT_W-1:0]  opCount,
  input  logic              invertA,
  input  logic              immValid,
  input  logic [DATA_W-1:0] immData,
  input  logic              isAdd,
  input  logic              divOvValid,
  input  logic              divOvValue,
  input  logic [DATA_W-1:0] result,
  input  logic              soIn,
  output logic              caVal,
  output logic              ca32Val,
  output logic              ovVal,
  output logic              ov32Val,
  output logic [3:0]        condVal
);
  localparam int SLOTS  = NUM_REG_OPS + 1;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] slotVal [SLOTS];
  logic [SLOTS-1:0]  slotUsed;
  logic [SLOTS-1:0]  gtFull;
  logic [SLOTS-1:0]  gtHalf;

  for (genvar k = 0; k < SLOTS; k++) begin : gSlot
    logic [DATA_W-1:0] regVal;
    logic isReg;
    logic isImm;
    if (k < NUM_REG_OPS) begin : gReg
      if (k == 0) begin : gFirst
        assign regVal = invertA ? ~regOps[k] : regOps[k];
      end else begin : gRest
        assign regVal = regOps[k];
      end
    end else begin : gNoReg
      assign regVal = '0;
    end
    assign isReg       = (CNT_W'(k) < opCount);
    assign isImm       = immValid && (CNT_W'(k) == opCount);
    assign slotUsed[k] = isReg | isImm;
    assign slotVal[k]  = isReg ? regVal : (isImm ? immData : '0);
    assign gtFull[k]   = slotUsed[k] && (slotVal[k] > result);
    assign gtHalf[k]   = slotUsed[k] &&
                         (slotVal[k][HALF_W-1:0] > result[HALF_W-1:0]);
  end

  // carry group
  logic addCarry32;
  assign addCarry32 = result[HALF_W] ^ slotVal[0][HALF_W] ^ slotVal[1][HALF_W];
  assign caVal   = |gtFull;
  assign ca32Val = isAdd ? addCarry32 : |gtHalf;

  // overflow group
  logic signA, signB, signR, sign32A, sign32B, sign32R;
  assign signA   = slotVal[0][DATA_W-1];
  assign signB   = slotVal[1][DATA_W-1];
  assign signR   = result[DATA_W-1];
  assign sign32A = slotVal[0][HALF_W-1];
  assign sign32B = slotVal[1][HALF_W-1];
  assign sign32R = result[HALF_W-1];

  assign ovVal   = divOvValid ? divOvValue : ((signA == signB) && (signR != signA));
  assign ov32Val = divOvValid ? divOvValue : ((sign32A == sign32B) && (sign32R != sign32A));

  // condition field
  logic isNeg, isZero;
  assign isNeg   = result[DATA_W-1];
  assign isZero  = (result == '0);
  assign condVal = {isNeg, !isNeg && !isZero, isZero, soIn};
endmodule

// File: rtl/intFlagUnit.sv
module intFlagUnit
  import intFlagPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [1:0]        opCount,
  input  logic              invertA,
  input  logic              immValid,
  input  logic [DATA_W-1:0] immData,
  input  logic              isAdd,
  input  logic              carryEn,
  input  logic              ovEn,
  input  logic              recEn,
  input  logic              divOvValid,
  input  logic              divOvValue,
  input  logic [1:0]        doneMask,
  input  logic [DATA_W-1:0] result,
  output logic              flagCa,
  output logic              flagCa32,
  output logic              flagOv,
  output logic              flagOv32,
  output logic              flagSo,
  output logic [3:0]        condField
);
  localparam int NUM_REG_OPS = 3;
  localparam int CNT_W       = $clog2(NUM_REG_OPS + 1);

  logic [DATA_W-1:0] regOps [NUM_REG_OPS];
  assign regOps[0] = opA;
  assign regOps[1] = opB;
  assign regOps[2] = opC;

  flagStrobes_t strobes;
  logic caVal, ca32Val, ovVal, ov32Val, soNext;
  logic [3:0] condVal;

  flagControl #(.CNT_W(CNT_W)) uCtrl (
    .opValid(opValid), .opCount(opCount), .immValid(immValid),
    .carryEn(carryEn), .ovEn(ovEn), .recEn(recEn),
    .divOvValid(divOvValid), .doneMask(doneMask), .strobes(strobes)
  );

  assign soNext = flagSo | (strobes.wrOver & ovVal);

  flagDatapath #(.DATA_W(DATA_W), .NUM_REG_OPS(NUM_REG_OPS), .CNT_W(CNT_W)) uPath (
    .regOps(regOps), .opCount(opCount), .invertA(invertA),
    .immValid(immValid), .immData(immData), .isAdd(isAdd),
    .divOvValid(divOvValid), .divOvValue(divOvValue), .result(result),
    .soIn(soNext), .caVal(caVal), .ca32Val(ca32Val), .ovVal(ovVal),
    .ov32Val(ov32Val), .condVal(condVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagCa    <= 1'b0;
      flagCa32  <= 1'b0;
      flagOv    <= 1'b0;
      flagOv32  <= 1'b0;
      flagSo    <= 1'b0;
      condField <= 4'b0;
    end else begin
      if (strobes.wrCarry)   flagCa   <= caVal;
      if (strobes.wrCarry32) flagCa32 <= ca32Val;
      if (strobes.wrOver) begin
        flagOv   <= ovVal;
        flagOv32 <= ov32Val;
        flagSo   <= soNext;
      end
      if (strobes.wrCond) condField <= condVal;
    end
  end

  assert_so_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagSo |=> flagSo);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable({flagCa, flagCa32, flagOv, flagOv32, flagSo, condField}));

  assert_div_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && ovEn && divOvValid) |=> (flagOv == $past(divOvValue)) &&
                                        (flagOv32 == $past(divOvValue)));

  assert_ca_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && doneMask[0]) |=> $stable(flagCa));

  assert_ca32_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && doneMask[1]) |=> $stable(flagCa32));

  assert_ov_skip_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !divOvValid && (({1'b0, opCount} + {2'b0, immValid}) < 3'd2))
      |=> $stable({flagOv, flagOv32, flagSo}));

  assert_cond_class_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(condField[3:1]));
endmodule

// File: tb/sim_intFlagUnit.sv
module sim_intFlagUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 0, invertA = 0, immValid = 0, isAdd = 0;
  logic carryEn = 0, ovEn = 0, recEn = 0, divOvValid = 0, divOvValue = 0;
  logic [1:0] opCount = 0, doneMask = 0;
  logic [63:0] opA = 0, opB = 0, opC = 0, immData = 0, result = 0;
  logic flagCa, flagCa32, flagOv, flagOv32, flagSo;
  logic [3:0] condField;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference state
  bit mCa, mCa32, mOv, mOv32, mSo;
  logic [3:0] mCond;

  always #4 clk = ~clk;

  intFlagUnit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opA(opA), .opB(opB), .opC(opC),
    .opCount(opCount), .invertA(invertA), .immValid(immValid), .immData(immData),
    .isAdd(isAdd), .carryEn(carryEn), .ovEn(ovEn), .recEn(recEn),
    .divOvValid(divOvValid), .divOvValue(divOvValue), .doneMask(doneMask),
    .result(result), .flagCa(flagCa), .flagCa32(flagCa32), .flagOv(flagOv),
    .flagOv32(flagOv32), .flagSo(flagSo), .condField(condField)
  );

  task automatic cmp1(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    cmp1(tag, "CA", flagCa, mCa);
    cmp1(tag, "CA32", flagCa32, mCa32);
    cmp1(tag, "OV", flagOv, mOv);
    cmp1(tag, "OV32", flagOv32, mOv32);
    cmp1(tag, "SO", flagSo, mSo);
    checks++;
    if (condField !== mCond) begin
      failures++;
      $display("FAIL %s COND actual=%04b expected=%04b", tag, condField, mCond);
    end
  endtask

  // behavioural reference: builds an operand queue and applies the rules
  task automatic refStep();
    logic [63:0] ops[$];
    logic [63:0] a, b, regs[3];
    bit ca, ca32, ov, ov32;
    longint sres;
    if (!opValid) return;
    regs[0] = opA; regs[1] = opB; regs[2] = opC;
    ops = {};
    for (int i = 0; i < int'(opCount); i++)
      ops.push_back((i == 0 && invertA) ? ~regs[i] : regs[i]);
    if (immValid) ops.push_back(immData);
    a = (ops.size() > 0) ? ops[0] : 64'd0;
    b = (ops.size() > 1) ? ops[1] : 64'd0;
    if (carryEn) begin
      ca = 0; ca32 = 0;
      foreach (ops[i]) begin
        if (ops[i] > result) ca = 1;
        if (ops[i][31:0] > result[31:0]) ca32 = 1;
      end
      if (isAdd) ca32 = result[32] ^ a[32] ^ b[32];
      if (!doneMask[0]) mCa = ca;
      if (!doneMask[1]) mCa32 = ca32;
    end
    if (ovEn && (ops.size() >= 2 || divOvValid)) begin
      if (divOvValid) begin
        ov = divOvValue; ov32 = divOvValue;
      end else begin
        ov   = (a[63] == b[63]) && (result[63] != a[63]);
        ov32 = (a[31] == b[31]) && (result[31] != a[31]);
      end
      mOv = ov; mOv32 = ov32; mSo = mSo | ov;
    end
    if (recEn) begin
      sres = $signed(result);
      mCond = {sres < 0, sres > 0, sres == 0, mSo};
    end
  endtask

  task automatic doOp(input logic [63:0] a, b, c, input logic [1:0] cnt,
                      input logic inv, immV, input logic [63:0] immD,
                      input logic add, cEn, oEn, rEn, dV, dVal,
                      input logic [1:0] mask, input logic [63:0] res,
                      input logic valid, input string tag);
    opA = a; opB = b; opC = c; opCount = cnt; invertA = inv; immValid = immV;
    immData = immD; isAdd = add; carryEn = cEn; ovEn = oEn; recEn = rEn;
    divOvValid = dV; divOvValue = dVal; doneMask = mask; result = res;
    opValid = valid;
    refStep();
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mCa = 0; mCa32 = 0; mOv = 0; mOv32 = 0; mSo = 0; mCond = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R3: all-ones plus one wraps to zero, carry out
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 64'd0, 1, "R3");
    // R2: inverted first operand (subtract form)
    doOp(64'd5, 64'd10, 0, 2, 1, 0, 0, 1, 1, 0, 1, 0, 0, 0, 64'd5, 1, "R2");
    // R2: immediate becomes second operand, no carry
    doOp(64'd3, 64'hFF, 64'hFF, 1, 0, 1, 64'h10, 1, 1, 1, 1, 0, 0, 0, 64'h13, 1, "R2");
    // R4: add rule for 32-bit carry
    doOp(64'h0000_0000_FFFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0,
         64'h0000_0001_0000_0000, 1, "R4");
    // R5: comparison rule for 32-bit carry
    doOp(64'h0000_0001_0000_0005, 64'd0, 0, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0,
         64'h0000_0002_0000_0003, 1, "R5");
    // R6: CA masked, CA32 written
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2'b01, 64'd0, 1, "R6");
    // R6: CA32 masked, CA written
    doOp(64'd1, 64'd1, 0, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2'b10, 64'd2, 1, "R6");
    // R7: 32-bit overflow only
    doOp(64'h7FFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 64'h8000_0000, 1, "R7");
    // R7: 64-bit overflow, R9 SO set
    doOp(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0,
         64'h8000_0000_0000_0000, 1, "R7");
    // R10: single operand, no override: overflow group held
    doOp(64'd1, 64'd0, 0, 1, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 64'd1, 1, "R10");
    // R8: override to 0 clears OV; R9: SO stays set
    doOp(64'd7, 64'd0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 64'd3, 1, "R8");
    doOp(64'd7, 64'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 64'd3, 1, "R9");
    doOp(64'd0, 64'd0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 64'd0, 1, "R8");
    // R11: negative result, then record off keeps field
    doOp(64'd0, 64'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 1, "R11");
    doOp(64'd0, 64'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 64'd9, 1, "R11");
    // R12: idle cycle with garbage inputs
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd2, 3, 1, 1, 64'd9, 1, 1, 1, 1, 1, 0, 0,
         64'd0, 0, "R12");
    // R12: enables off while valid
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 64'd0, 1, "R12");
    // three register operands plus immediate, R3 with fourth operand largest
    doOp(64'd1, 64'd2, 64'd3, 3, 0, 1, 64'd100, 0, 1, 1, 1, 0, 0, 0, 64'd50, 1, "R3");
    // R9: reset clears SO
    opValid = 0; rstN = 0;
    @(negedge clk);
    rstN = 1;
    mCa = 0; mCa32 = 0; mOv = 0; mOv32 = 0; mSo = 0; mCond = 0;
    @(negedge clk);
    checkAll("R9");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule